// File: doc/BRIEF.md
# Variable-Amount Barrel Shift Unit

This block is the shift stage of a small RISC integer datapath. It moves a data word left or right by 0 to 31 bit positions in one combinational pass, filling the vacated positions with zeros or with copies of the sign bit. The outputs depend only on the present inputs. There is no clock and no stored state.

The shift distance comes from one of two sources. It is either a 5-bit amount taken from the instruction, or the low bits of a second register operand. A 3-bit operation code picks the direction, the fill rule and the amount source. Instruction decode, the register file and any pipeline registers sit outside the block. The surrounding datapath supplies the operand, both candidate amounts and the code, and takes the result in the same cycle.

Top module: `shf_unit`

## Requirements
- R1: Op code 3'b000 shifts `data_i` left by `imm_amt_i` and puts zeros into the vacated low-order bits.
- R2: Op code 3'b010 shifts `data_i` right by `imm_amt_i` and puts zeros into the vacated high-order bits.
- R3: Op code 3'b011 shifts `data_i` right by `imm_amt_i` and puts copies of `data_i[31]` into the vacated high-order bits, so a negative operand gives a negative result.
- R4: Op codes 3'b100, 3'b110 and 3'b111 perform the same operations as 3'b000, 3'b010 and 3'b011. Their amount is `reg_amt_i[4:0]`, and `reg_amt_i[31:5]` has no effect on the result.
- R5: The immediate forms (bit 2 of the code clear) ignore `reg_amt_i`. The register forms (bit 2 set) ignore `imm_amt_i`.
- R6: An effective amount of zero returns `data_i` unchanged for every op code.
- R7: Shifting the value 2 left by 3 gives 16. Shifting the value 16 right logically by 3 gives 2.
- R8: The result is purely combinational and settles within the same clock period in which the inputs change.
- R9: The unassigned codes decode by bit. 3'b001 behaves as 3'b000 and 3'b101 behaves as 3'b100: bit 0 only selects sign fill when bit 1 (right) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code: bit 2 selects the register amount, bit 1 selects right, bit 0 selects sign fill |
| data_i | input | 32 | Operand to shift |
| imm_amt_i | input | 5 | Shift amount taken from the instruction |
| reg_amt_i | input | 32 | Register operand whose low 5 bits give the variable amount |
| result_o | output | 32 | Shifted result |

## Verification
The bench sweeps every op code, including the two unassigned ones, across all 32 amounts and a set of operands. The operands include zero, all ones, a lone sign bit, a lone low bit and mixed patterns. In each case the other amount source carries an unrelated value, and the upper register bits carry garbage. Each of these targets a specific fault:
- Swapping the zero fill for a sign fill corrupts the high bits of negative operands.
- A fill that is wired backwards shows up at the low end of left shifts.
- Using the wrong amount source gives results that follow the decoy value.
- Using more than five register bits breaks every variable case that has garbage above bit 4.
- A bypass error appears at amount zero, where the operand must come back unchanged.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int OP_W   = 3;

    // op code bit roles
    localparam int OPB_ARITH = 0;
    localparam int OPB_RIGHT = 1;
    localparam int OPB_VAR   = 2;

    localparam logic [OP_W-1:0] OP_SLL  = 3'b000;
    localparam logic [OP_W-1:0] OP_SRL  = 3'b010;
    localparam logic [OP_W-1:0] OP_SRA  = 3'b011;
    localparam logic [OP_W-1:0] OP_SLLV = 3'b100;
    localparam logic [OP_W-1:0] OP_SRLV = 3'b110;
    localparam logic [OP_W-1:0] OP_SRAV = 3'b111;

    typedef struct packed {
        logic var_src;   // amount from register operand
        logic right;     // shift toward bit 0
        logic arith;     // replicate sign into vacated bits
    } shf_ctrl_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output shf_ctrl_t       ctrl_o
);

    shf_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d         = '0;
        ctrl_d.var_src = op_i[OPB_VAR];
        ctrl_d.right   = op_i[OPB_RIGHT];
        // sign fill only has meaning for right shifts
        ctrl_d.arith   = op_i[OPB_RIGHT] & op_i[OPB_ARITH];
    end

    assign ctrl_o = ctrl_d;

    always_comb begin
        p_arith_needs_right_r9: assert (!(ctrl_o.arith && !op_i[OPB_RIGHT]))
            else $error("sign fill selected for a left shift");
    end

endmodule

// File: rtl/shf_amt_sel.sv
module shf_amt_sel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic              var_src_i,
    input  logic [AMT_W-1:0]  imm_amt_i,
    input  logic [DATA_W-1:0] reg_amt_i,
    output logic [AMT_W-1:0]  amt_o
);

    logic [AMT_W-1:0] amt_d;
    logic             unused_reg_hi;

    // only the low bits of the register operand count
    assign unused_reg_hi = ^reg_amt_i[DATA_W-1:AMT_W];

    always_comb begin
        amt_d = imm_amt_i;
        if (var_src_i) begin
            amt_d = reg_amt_i[AMT_W-1:0];
        end
    end

    assign amt_o = amt_d;

    always_comb begin
        p_imm_source_r5: assert (var_src_i || amt_o == imm_amt_i)
            else $error("immediate form took a register amount");
        p_reg_low_bits_r4: assert (!var_src_i || amt_o == reg_amt_i[AMT_W-1:0])
            else $error("variable form took a wrong amount");
    end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              fill_i,
    output logic [DATA_W-1:0] dout_o
);

    // right-shifting log stages; stage k moves by 2**k when amt_i[k] is set
    logic [DATA_W-1:0] stage_d [AMT_W+1];

    assign stage_d[0] = din_i;

    genvar k;
    generate
        for (k = 0; k < AMT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stage_d[k+1] = amt_i[k]
                ? {{SH{fill_i}}, stage_d[k][DATA_W-1:SH]}
                : stage_d[k];
        end
    endgenerate

    assign dout_o = stage_d[AMT_W];

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  imm_amt_i,
    input  logic [DATA_W-1:0] reg_amt_i,
    output logic [DATA_W-1:0] result_o
);

    shf_ctrl_t         ctrl;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] pre_d;
    logic [DATA_W-1:0] core_q;
    logic [DATA_W-1:0] res_d;
    logic              fill_d;

    shf_decode u_decode (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    shf_amt_sel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_amt (
        .var_src_i (ctrl.var_src),
        .imm_amt_i (imm_amt_i),
        .reg_amt_i (reg_amt_i),
        .amt_o     (amt)
    );

    // left shifts reuse the right shifter on a bit-reversed word
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            pre_d[i] = ctrl.right ? data_i[i] : data_i[DATA_W-1-i];
        end
        fill_d = ctrl.arith & data_i[DATA_W-1];
    end

    shf_barrel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_barrel (
        .din_i  (pre_d),
        .amt_i  (amt),
        .fill_i (fill_d),
        .dout_o (core_q)
    );

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            res_d[i] = ctrl.right ? core_q[i] : core_q[DATA_W-1-i];
        end
    end

    assign result_o = res_d;

    always_comb begin
        p_zero_amt_pass_r6: assert (amt != '0 || result_o == data_i)
            else $error("zero amount altered operand");
        p_sign_kept_r3: assert (!(ctrl.arith && data_i[DATA_W-1]) || result_o[DATA_W-1])
            else $error("arithmetic shift lost sign");
        p_left_zero_fill_r1: assert (ctrl.right || amt == '0 || !result_o[0])
            else $error("left shift filled low bit with one");
        p_right_zero_fill_r2: assert (!ctrl.right || ctrl.arith || amt == '0 || !result_o[DATA_W-1])
            else $error("logical right shift filled high bit with one");
    end

endmodule

// File: tb/tb_shf_unit.sv
`timescale 1ns/1ps
module tb_shf_unit;

    logic        clk = 1'b0;
    logic [2:0]  op_i;
    logic [31:0] data_i;
    logic [4:0]  imm_amt_i;
    logic [31:0] reg_amt_i;
    logic [31:0] result_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    shf_unit dut (
        .op_i      (op_i),
        .data_i    (data_i),
        .imm_amt_i (imm_amt_i),
        .reg_amt_i (reg_amt_i),
        .result_o  (result_o)
    );

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] d,
                                          input logic [4:0] ia, input logic [31:0] ra);
        int amt;
        logic [31:0] r;
        amt = op[2] ? int'(ra[4:0]) : int'(ia);
        if (!op[1]) begin
            r = d;
            for (int s = 0; s < amt; s++) r = r * 2;
        end else begin
            r = d;
            for (int s = 0; s < amt; s++) r = {op[0] & d[31], r[31:1]};
        end
        return r;
    endfunction

    task automatic chk(input logic [31:0] exp, input string req);
        n_chk++;
        if (result_o !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b d=%h imm=%0d reg=%h actual=%h expected=%h",
                     req, op_i, data_i, imm_amt_i, reg_amt_i, result_o, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [31:0] d,
                         input logic [4:0] ia, input logic [31:0] ra, input string req);
        @(posedge clk);
        op_i = op; data_i = d; imm_amt_i = ia; reg_amt_i = ra;
        @(negedge clk);  // R8: settled within half a period, no edge needed
        chk(model(op, d, ia, ra), req);
    endtask

    function automatic string tag_of(input logic [2:0] op, input int amt);
        if (amt == 0)      return "R6";
        if (op == 3'b001 || op == 3'b101) return "R9";
        if (op[2])         return "R4";
        if (!op[1])        return "R1";
        if (!op[0])        return "R2";
        return "R3";
    endfunction

    logic [31:0] pats [9] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h0000_0010,
                              32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'hA5C3_0F96,
                              32'h8421_0001};

    initial begin
        op_i = '0; data_i = '0; imm_amt_i = '0; reg_amt_i = '0;
        #1;
        // R6 at rest: all-zero inputs pass zero through
        chk(32'h0, "R6");

        // R7 worked examples
        apply(3'b000, 32'd2, 5'd3, 32'hFFFF_FFE0, "R7");
        chk(32'd16, "R7");
        apply(3'b010, 32'd16, 5'd3, 32'h0000_001F, "R7");
        chk(32'd2, "R7");
        apply(3'b100, 32'd2, 5'd0, 32'hABCD_E003, "R7");
        chk(32'd16, "R7");

        // exhaustive sweep: all op codes, all amounts, operand patterns
        for (int o = 0; o < 8; o++) begin
            for (int a = 0; a < 32; a++) begin
                for (int p = 0; p < 9; p++) begin
                    logic [2:0]  op;
                    logic [4:0]  ia;
                    logic [31:0] ra;
                    op = 3'(o);
                    // the unused source carries a decoy (R5), upper reg bits garbage (R4)
                    ia = op[2] ? 5'(a ^ 13) : 5'(a);
                    ra = op[2] ? {27'h5A5_A5A5 ^ 27'(p), 5'(a)} : {27'h7FF_FFFF, 5'(31 - a)};
                    apply(op, pats[p], ia, ra, tag_of(op, a));
                end
            end
        end

        // R5: immediate form unaffected by changing the register operand
        apply(3'b011, 32'h9000_0000, 5'd4, 32'h0000_0000, "R5");
        chk(32'hF900_0000, "R5");
        apply(3'b011, 32'h9000_0000, 5'd4, 32'hFFFF_FFFF, "R5");
        chk(32'hF900_0000, "R5");
        // R5: variable form unaffected by the immediate field
        apply(3'b110, 32'h9000_0000, 5'd31, 32'h0000_0004, "R5");
        chk(32'h0900_0000, "R5");
        // R3 and R2 contrast at the extreme amount
        apply(3'b111, 32'h8000_0000, 5'd0, 32'hFFFF_FFFF, "R3");
        chk(32'hFFFF_FFFF, "R3");
        apply(3'b010, 32'h8000_0000, 5'd31, 32'h0, "R2");
        chk(32'h0000_0001, "R2");
        // R1 at maximum
        apply(3'b000, 32'hFFFF_FFFF, 5'd31, 32'h0, "R1");
        chk(32'h8000_0000, "R1");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule